// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block merges every reason a device can be reset into one synchronous device reset and one open-drain reset-out drive. There are five causes: a power-on pin, an external reset pin, a watchdog event (expiry or a bad key write), a software write to the control word, and a bus access that lands in an illegal address window. Any cause pulls the device reset low for at least a programmable stretch, so that external parts on the reset-out pin see a clean pulse. A pin that is held low holds the reset for as long as it stays low.

The two asynchronous pins pass through two-flop synchronizers, and the reset is always released on a clock edge. A small status word records which cause fired. These flags are sticky: a reset does not clear them, so software can read them after it restarts. Software clears a flag by writing 1 to it. A power-on event loads the status word with only the power-on flag set. It also holds a separate clear output for the clock configuration logic, which no other cause touches.

Top module: `sys_reset_hub`

## Requirements
- R1: A one-cycle internal cause (watchdog expiry, watchdog bad key, software reset, illegal access) sampled on clock edge E drives `dev_rst_n` low and `rst_pin_drive` high from edge E through edge E+STRETCH-1. The reset is released at edge E+STRETCH. STRETCH defaults to 8.
- R2: While `ext_rst_n` is low, `dev_rst_n` stays low. The pin reaches the reset logic two edges late through its synchronizer. A low level covering W edges therefore gives STRETCH+W-1 low cycles, starting two cycles after the first edge.
- R3: A low level on `ext_rst_n` covering a single clock edge is recognised, and it gives a full STRETCH-cycle reset.
- R4: A control write (`ctl_wr`) resets the device when control bit 14 is 0 (`ctl_wbits[0]`) or control bit 15 is 1 (`ctl_wbits[1]`). The combination bit 15 = 0, bit 14 = 1 has no effect on the reset or on the flags.
- R5: `status` bit 15 is the power-on flag, bit 12 the illegal-access flag, bit 10 the software flag and bit 9 the watchdog flag. All other bits read 0.
- R6: A cause sets its flag. No reset clears a flag.
- R7: A `stat_clr` write clears exactly the flags whose mask bits are 1, in the mask order {power-on, illegal, software, watchdog}. Mask bits that are 0 leave their flags unchanged.
- R8: A valid bus access whose address lies in 16'h0800–16'h6FFF or 16'h7800–16'h7FFF (the default windows, bounds inclusive) causes a reset. Any other address causes no reset.
- R9: `clkcfg_rst_n` is low only during a power-on reset. It rises on the same edge as `dev_rst_n`. Other causes leave it high.
- R10: While `por_n` is low, `dev_rst_n` is low and `status` reads 16'h8000. After `por_n` rises between two edges, `dev_rst_n` first reads high after the (STRETCH+2)-th edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset pin, active low, asynchronous |
| ext_rst_n | input | 1 | External reset request level, active low, asynchronous |
| wd_expire | input | 1 | Watchdog counter overflow pulse |
| wd_badkey | input | 1 | Watchdog illegal key or control write pulse |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wbits | input | 2 | Written control bits {bit 15, bit 14} |
| stat_wr | input | 1 | Status flag clear strobe |
| stat_clr | input | 4 | Clear mask {power-on, illegal, software, watchdog} |
| bus_valid | input | 1 | Peripheral-frame access valid |
| bus_addr | input | AW | Peripheral-frame access address |
| dev_rst_n | output | 1 | Device reset, active low, synchronous release |
| rst_pin_drive | output | 1 | 1 = pull the reset-out pin low |
| clkcfg_rst_n | output | 1 | Clock configuration clear, power-on only |
| status | output | 16 | Sticky reset-cause flags |

## Verification
The bench builds the block with its defaults: a 16-bit address, a stretch of 8 and two illegal windows. At these values a strided sweep of the whole address space, plus every window bound and its neighbours, exercises each range comparison on both sides. All four combinations of the two control bits are driven. External pulses of 1 to 4 edges, and one held for 20, show how the hold adds to the stretch. A second power-on in mid-run checks that the flags return to the power-on pattern.

// File: rtl/rsthub_pkg.sv
package rsthub_pkg;
  localparam int FLAG_POR = 15;
  localparam int FLAG_ILL = 12;
  localparam int FLAG_SW  = 10;
  localparam int FLAG_WD  = 9;
  localparam int STAT_W   = 16;

  typedef struct packed {
    logic por;
    logic ill;
    logic sw;
    logic wd;
  } cause_t;
endpackage

// File: rtl/rsthub_sync.sv
module rsthub_sync #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/rsthub_illdec.sv
module rsthub_illdec #(
  parameter int AW = 16,
  parameter int NUM_RNG = 2,
  parameter logic [NUM_RNG*AW-1:0] RNG_LO = {16'h7800, 16'h0800},
  parameter logic [NUM_RNG*AW-1:0] RNG_HI = {16'h7FFF, 16'h6FFF}
) (
  input  logic          valid,
  input  logic [AW-1:0] addr,
  output logic          hit
);
  logic [NUM_RNG-1:0] in_rng;

  for (genvar g = 0; g < NUM_RNG; g++) begin : g_rng
    assign in_rng[g] = (addr >= RNG_LO[g*AW +: AW]) && (addr <= RNG_HI[g*AW +: AW]);
  end

  assign hit = valid && (|in_rng);
endmodule

// File: rtl/rsthub_stretch.sv
module rsthub_stretch #(
  parameter int STRETCH = 8
) (
  input  logic clk,
  input  logic arst_n,
  input  logic req,
  input  logic por_hold,
  output logic rst_n,
  output logic clkcfg_rst_n
);
  localparam int CW = $clog2(STRETCH + 1);
  localparam logic [CW-1:0] LOAD = CW'(STRETCH);

  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          rst_n_q, rst_n_nxt;
  logic          por_ph_q, por_ph_nxt;

  always_comb begin
    cnt_nxt = cnt_q;
    if (req) begin
      cnt_nxt = LOAD;
    end else if (cnt_q != '0) begin
      cnt_nxt = cnt_q - 1'b1;
    end
    rst_n_nxt  = (cnt_nxt == '0);
    por_ph_nxt = por_hold || (por_ph_q && (cnt_nxt != '0));
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q    <= LOAD;
      rst_n_q  <= 1'b0;
      por_ph_q <= 1'b1;
    end else begin
      cnt_q    <= cnt_nxt;
      rst_n_q  <= rst_n_nxt;
      por_ph_q <= por_ph_nxt;
    end
  end

  assign rst_n        = rst_n_q;
  assign clkcfg_rst_n = !por_ph_q;

  AST_STRETCH_COUNTDOWN: assert property (@(posedge clk) disable iff (!arst_n)
    (cnt_q != '0 && !req) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R1
  AST_REQ_RELOADS: assert property (@(posedge clk) disable iff (!arst_n)
    req |=> (cnt_q == LOAD && !rst_n_q)); // R1
  AST_CLKCFG_INSIDE_RST: assert property (@(posedge clk) disable iff (!arst_n)
    !clkcfg_rst_n |-> !rst_n_q); // R9
endmodule

// File: rtl/rsthub_flags.sv
module rsthub_flags
  import rsthub_pkg::*;
(
  input  logic              clk,
  input  logic              arst_n,
  input  cause_t            set,
  input  logic              clr_wr,
  input  logic [3:0]        clr_mask,
  output logic [STAT_W-1:0] status
);
  cause_t     flags_q, flags_nxt;
  logic [3:0] flags_vec, set_vec, clr_vec;

  assign set_vec   = set;
  assign clr_vec   = clr_wr ? clr_mask : 4'b0000;
  assign flags_vec = flags_q;

  always_comb begin
    flags_nxt = cause_t'(set_vec | (flags_vec & ~clr_vec));
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      flags_q <= '{por: 1'b1, ill: 1'b0, sw: 1'b0, wd: 1'b0};
    end else begin
      flags_q <= flags_nxt;
    end
  end

  always_comb begin
    status           = '0;
    status[FLAG_POR] = flags_q.por;
    status[FLAG_ILL] = flags_q.ill;
    status[FLAG_SW]  = flags_q.sw;
    status[FLAG_WD]  = flags_q.wd;
  end

  AST_FLAG_SET_ON_CAUSE: assert property (@(posedge clk) disable iff (!arst_n)
    (set_vec != 4'b0000) |=> ((flags_vec & $past(set_vec)) == $past(set_vec))); // R6
  AST_FLAG_NO_SELF_CLEAR: assert property (@(posedge clk) disable iff (!arst_n)
    !clr_wr |=> ((flags_vec & $past(flags_vec)) == $past(flags_vec))); // R6
endmodule

// File: rtl/sys_reset_hub.sv
module sys_reset_hub
  import rsthub_pkg::*;
#(
  parameter int AW = 16,
  parameter int STRETCH = 8,
  parameter int NUM_ILL = 2,
  parameter logic [NUM_ILL*AW-1:0] ILL_LO = {16'h7800, 16'h0800},
  parameter logic [NUM_ILL*AW-1:0] ILL_HI = {16'h7FFF, 16'h6FFF}
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              ext_rst_n,
  input  logic              wd_expire,
  input  logic              wd_badkey,
  input  logic              ctl_wr,
  input  logic [1:0]        ctl_wbits,
  input  logic              stat_wr,
  input  logic [3:0]        stat_clr,
  input  logic              bus_valid,
  input  logic [AW-1:0]     bus_addr,
  output logic              dev_rst_n,
  output logic              rst_pin_drive,
  output logic              clkcfg_rst_n,
  output logic [STAT_W-1:0] status
);
  logic   por_q, ext_q;
  logic   por_hold, ext_hold;
  logic   wd_evt, sw_evt, ill_hit, req;
  cause_t causes;

  rsthub_sync #(.RST_VAL(1'b0)) u_por_sync (
    .clk(clk), .arst_n(por_n), .d(1'b1), .q(por_q)
  );
  rsthub_sync #(.RST_VAL(1'b1)) u_ext_sync (
    .clk(clk), .arst_n(por_n), .d(ext_rst_n), .q(ext_q)
  );

  rsthub_illdec #(
    .AW(AW), .NUM_RNG(NUM_ILL), .RNG_LO(ILL_LO), .RNG_HI(ILL_HI)
  ) u_illdec (
    .valid(bus_valid), .addr(bus_addr), .hit(ill_hit)
  );

  assign por_hold = !por_q;
  assign ext_hold = !ext_q;
  assign wd_evt   = wd_expire || wd_badkey;
  assign sw_evt   = ctl_wr && (ctl_wbits[1] || !ctl_wbits[0]);
  assign req      = por_hold || ext_hold || wd_evt || sw_evt || ill_hit;

  always_comb begin
    causes.por = por_hold;
    causes.ill = ill_hit;
    causes.sw  = sw_evt;
    causes.wd  = wd_evt;
  end

  rsthub_stretch #(.STRETCH(STRETCH)) u_stretch (
    .clk(clk), .arst_n(por_n), .req(req), .por_hold(por_hold),
    .rst_n(dev_rst_n), .clkcfg_rst_n(clkcfg_rst_n)
  );

  rsthub_flags u_flags (
    .clk(clk), .arst_n(por_n), .set(causes),
    .clr_wr(stat_wr), .clr_mask(stat_clr), .status(status)
  );

  assign rst_pin_drive = !dev_rst_n;

  AST_EXT_HOLDS_RESET: assert property (@(posedge clk) disable iff (!por_n)
    !ext_q |=> !dev_rst_n); // R2
  AST_SW_RESET_FLAGGED: assert property (@(posedge clk) disable iff (!por_n)
    sw_evt |=> (!dev_rst_n && status[FLAG_SW])); // R4
  AST_ILL_RESET_FLAGGED: assert property (@(posedge clk) disable iff (!por_n)
    ill_hit |=> (!dev_rst_n && status[FLAG_ILL])); // R8
  AST_WD_RESET_FLAGGED: assert property (@(posedge clk) disable iff (!por_n)
    wd_evt |=> (!dev_rst_n && status[FLAG_WD])); // R1
  AST_SPARE_BITS_ZERO: assert property (@(posedge clk) disable iff (!por_n)
    (status & 16'h69FF) == 16'h0000); // R5
endmodule

// File: tb/sys_reset_hub_bench.sv
module sys_reset_hub_bench;
  localparam int ST = 8;

  logic        clk = 1'b0;
  logic        por_n, ext_rst_n, wd_expire, wd_badkey, ctl_wr, stat_wr, bus_valid;
  logic [1:0]  ctl_wbits;
  logic [3:0]  stat_clr;
  logic [15:0] bus_addr;
  logic        dev_rst_n, rst_pin_drive, clkcfg_rst_n;
  logic [15:0] status;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  sys_reset_hub u_sys_reset_hub (
    .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .wd_expire(wd_expire),
    .wd_badkey(wd_badkey), .ctl_wr(ctl_wr), .ctl_wbits(ctl_wbits),
    .stat_wr(stat_wr), .stat_clr(stat_clr), .bus_valid(bus_valid),
    .bus_addr(bus_addr), .dev_rst_n(dev_rst_n), .rst_pin_drive(rst_pin_drive),
    .clkcfg_rst_n(clkcfg_rst_n), .status(status)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // kinds: 0 wd expire, 1 wd bad key, 2 control write, 3 bus access, 4 ext pin low
  task automatic apply(int kind, bit on, logic [15:0] val);
    case (kind)
      0: wd_expire = on;
      1: wd_badkey = on;
      2: begin ctl_wr = on; ctl_wbits = val[1:0]; end
      3: begin bus_valid = on; bus_addr = val; end
      default: ext_rst_n = !on;
    endcase
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (dev_rst_n) break;
    end
  endtask

  task automatic run(int kind, int width, logic [15:0] val,
                     output int first, output int nlow, output int pin_low, output int cfg_low);
    wait_idle();
    first = -1; nlow = 0; pin_low = 0; cfg_low = 0;
    @(negedge clk);
    apply(kind, 1'b1, val);
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (!dev_rst_n) begin
        if (first < 0) first = i;
        nlow++;
      end
      if (rst_pin_drive) pin_low++;
      if (!clkcfg_rst_n) cfg_low++;
      if (i == width - 1) apply(kind, 1'b0, val);
    end
  endtask

  task automatic clear_flags(logic [3:0] m);
    @(negedge clk);
    stat_wr = 1'b1; stat_clr = m;
    @(negedge clk);
    stat_wr = 1'b0; stat_clr = 4'b0000;
  endtask

  task automatic check_por_release(string tag);
    int hi_at;
    hi_at = -1;
    @(negedge clk);
    por_n = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (hi_at < 0 && dev_rst_n) begin
        hi_at = i;
        chk({tag, " R9 clkcfg release edge"}, int'(clkcfg_rst_n), 1);
      end
      if (hi_at < 0 && i == 0) chk({tag, " R9 clkcfg low in power-on"}, int'(clkcfg_rst_n), 0);
    end
    chk({tag, " R10 release edge"}, hi_at, ST + 1);
  endtask

  initial begin
    int f, n, p, c;
    bit ill;
    logic [15:0] bnd [10];
    por_n = 1'b0; ext_rst_n = 1'b1; wd_expire = 1'b0; wd_badkey = 1'b0;
    ctl_wr = 1'b0; ctl_wbits = 2'b01; stat_wr = 1'b0; stat_clr = 4'b0000;
    bus_valid = 1'b0; bus_addr = 16'h0000;

    repeat (3) @(negedge clk);
    chk("R10 reset held while por low", int'(dev_rst_n), 0);
    chk("R10 status in power-on", int'(status), 16'h8000);
    chk("R1 pin driven in power-on", int'(rst_pin_drive), 1);
    check_por_release("first");
    chk("R5 power-on flag kept after release", int'(status), 16'h8000);

    // watchdog causes
    for (int k = 0; k < 2; k++) begin
      clear_flags(4'b1111);
      run(k, 1, 16'h0, f, n, p, c);
      chk("R1 wd first low", f, 0);
      chk("R1 wd low length", n, ST);
      chk("R1 pin follows reset", p, ST);
      chk("R9 clkcfg untouched by wd", c, 0);
      chk("R6 wd flag survives its reset", int'(status), 16'h0200);
    end

    // software control bits sweep: reset when bit14==0 or bit15==1
    for (int v = 0; v < 4; v++) begin
      clear_flags(4'b1111);
      run(2, 1, 16'(v), f, n, p, c);
      ill = (v[0] == 1'b0) || (v[1] == 1'b1);
      chk("R4 sw low length", n, ill ? ST : 0);
      chk("R4 sw flag", int'(status), ill ? 16'h0400 : 16'h0000);
    end

    // external pin, short pulses and a long hold
    for (int w = 1; w <= 4; w++) begin
      run(4, w, 16'h0, f, n, p, c);
      chk("R3 ext pulse first low", f, 2);
      chk("R2 ext low length", n, ST + w - 1);
    end
    run(4, 20, 16'h0, f, n, p, c);
    chk("R2 ext long hold length", n, ST + 19);

    // illegal address sweep: strided plus boundaries
    bnd = '{16'h0000, 16'h07FF, 16'h0800, 16'h6FFF, 16'h7000,
            16'h77FF, 16'h7800, 16'h7FFF, 16'h8000, 16'hFFFF};
    for (int j = 0; j < 10 + 311; j++) begin
      logic [15:0] a;
      a = (j < 10) ? bnd[j] : 16'((j - 10) * 211);
      ill = ((a >= 16'h0800) && (a <= 16'h6FFF)) || ((a >= 16'h7800) && (a <= 16'h7FFF));
      clear_flags(4'b0100);
      run(3, 1, a, f, n, p, c);
      chk($sformatf("R8 addr %h low length", a), n, ill ? ST : 0);
      chk($sformatf("R6 addr %h ill flag", a), int'(status[12]), ill ? 1 : 0);
    end

    // selective clear
    clear_flags(4'b1111);
    run(0, 1, 16'h0, f, n, p, c);
    run(2, 1, 16'h0, f, n, p, c);
    chk("R6 two flags accumulate", int'(status), 16'h0600);
    clear_flags(4'b0000);
    chk("R7 zero mask keeps flags", int'(status), 16'h0600);
    clear_flags(4'b0001);
    chk("R7 clear only wd flag", int'(status), 16'h0400);

    // second power-on mid-run
    @(negedge clk);
    por_n = 1'b0;
    @(negedge clk);
    chk("R10 second power-on status", int'(status), 16'h8000);
    chk("R9 clkcfg low on second power-on", int'(clkcfg_rst_n), 0);
    check_por_release("second");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule